// File: doc/BRIEF.md
# BCH8 Error Location Mapper

This block sits after an 8-error BCH locator that serves one 512-byte sector protected by 13 code bytes, the pair forming a 525-byte codeword. A 14th computed byte is a reserved pad and is always treated as zero. The block reverses the byte order of the 13 meaningful computed bytes to form the syndrome that the locator expects. On a start pulse it screens the sector. An all-zero computed syndrome means the sector is clean. All-0xFF stored code bytes mean the page is erased. A failure flag from the locator, or an error count above the limit, ends the job with a failure code.

When the sector passes screening, the block walks the latched list of bit locations, one per clock. Locations count backward from the end of the codeword. Each one becomes a flip command aimed either at sector data or at the stored code bytes. A location beyond the codeword emits no command and marks the result as bad. A single `done` pulse then reports the outcome.

Top module: `bch_errloc_mapper`

## Requirements
- R1: `syn_rev` byte g (bits 8g+7:8g) equals computed byte 12-g for g in 0..12. `syn_rev` byte 13 is always zero, whatever computed byte 13 holds.
- R2: If computed bytes 0..12 are all 0x00 when `start` is sampled in idle, `done` is high after that same edge with `res_code`=0 (OK) and `res_count`=0. No write is issued. Computed byte 13, the locator failure flag and the list are ignored.
- R3: If R2 does not apply and all 13 stored bytes are 0xFF, the result is the same as in R2 (OK, zero, no writes), even when the locator signals failure. If any single stored byte differs from 0xFF, the sector is not treated as erased.
- R4: If neither R2 nor R3 applies and either `loc_fail` is high or `loc_count` exceeds 8, `done` follows the start edge with `res_code`=1 (FAIL) and `res_count`=0. No write is issued.
- R5: For an accepted list of n locations (1..8) sampled at edge k, the command for location i is presented after edge k+1+i. `done` is high for exactly one cycle, after edge k+n+1.
- R6: For location L, the codeword byte position is 524 - floor(L/8) and `wr_mask` = 1 << (L mod 8).
- R7: A position below 512 gives a command with `wr_ecc`=0 and `wr_addr` = position.
- R8: A position from 512 to 524 gives a command with `wr_ecc`=1 and `wr_addr` = position - 512.
- R9: A location with floor(L/8) > 524 emits no command and forces `res_code`=2 (BADLOC). The valid locations in the same list are still written in order.
- R10: With `done`, `res_count` equals the number of commands issued for the job. `res_code` is 0 when every location was valid. After reset, `done`, `wr_valid` and `res_code` are 0.
- R11: An accepted job with `loc_count`=0 completes after the start edge with OK and a count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a job; sampled only while idle |
| calc_ecc | input | 112 | Computed code bytes, byte i at bits 8i+7:8i |
| stored_ecc | input | 104 | Stored code bytes read from the spare area |
| loc_fail | input | 1 | Locator reports an uncorrectable sector |
| loc_count | input | 4 | Number of locations in the list |
| loc_list | input | 104 | Locations, entry i at bits 13i+12:13i |
| syn_rev | output | 112 | Byte-reversed syndrome for the locator |
| wr_valid | output | 1 | Flip command valid this cycle |
| wr_ecc | output | 1 | Target: 0 sector data, 1 stored code bytes |
| wr_addr | output | 9 | Byte address inside the target |
| wr_mask | output | 8 | One-hot bit to flip |
| done | output | 1 | One-cycle completion pulse |
| res_code | output | 2 | 0 OK, 1 FAIL, 2 BADLOC; valid with done |
| res_count | output | 4 | Commands issued; valid with done |

## Verification
The screening checks and the locator failure flag are all judged on the same start edge, so two of them can be true together. The bench presents an erased page while the failure flag is high, and a zero syndrome while the flag is high and a list is loaded. It expects the OK code, no flip command, and `done` on the cycle right after start. A complementary case makes one stored byte 0xFE with the flag high and expects FAIL. This shows that the erased screen takes precedence only when the page is fully erased.

// File: rtl/bch_map_pkg.sv
// Shared types for the BCH error location mapper.
package bch_map_pkg;
    typedef enum logic [1:0] {
        RES_OK     = 2'd0,
        RES_FAIL   = 2'd1,
        RES_BADLOC = 2'd2
    } res_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_FIN  = 2'd2
    } st_e;
endpackage

// File: rtl/ecc_screen.sv
// Screening of the computed and stored code bytes.
// Produces the byte-reversed syndrome with the pad byte forced to zero,
// a flag for an all-zero syndrome and a flag for an erased (all 0xFF) page.
// Assumes ECC_BYTES >= CODE_BYTES; bytes above CODE_BYTES are pads.
module ecc_screen #(
    parameter int CODE_BYTES = 13,
    parameter int ECC_BYTES  = 14
) (
    input  logic [ECC_BYTES*8-1:0]  calc_ecc,
    input  logic [CODE_BYTES*8-1:0] stored_ecc,
    output logic [ECC_BYTES*8-1:0]  syn_rev,
    output logic                    syn_zero,
    output logic                    erased
);
    logic [CODE_BYTES-1:0] byte_zero;
    logic [CODE_BYTES-1:0] byte_ff;

    // Per code byte: reversal and the two screening tests.
    for (genvar g = 0; g < CODE_BYTES; g++) begin : g_code
        assign syn_rev[g*8 +: 8] = calc_ecc[(CODE_BYTES-1-g)*8 +: 8];
        assign byte_zero[g]      = (calc_ecc[g*8 +: 8] == 8'h00);
        assign byte_ff[g]        = (stored_ecc[g*8 +: 8] == 8'hFF);
    end

    // Pad bytes: always presented as zero.
    for (genvar p = CODE_BYTES; p < ECC_BYTES; p++) begin : g_pad
        assign syn_rev[p*8 +: 8] = 8'h00;
    end

    assign syn_zero = &byte_zero;
    assign erased   = &byte_ff;
endmodule

// File: rtl/loc_decode.sv
// Decodes one backward-counted bit location into a flip command.
// Byte position = LIMIT-1 - floor(loc/8), LIMIT = SECT_BYTES + CODE_BYTES.
// Assumes LIMIT fits in LOC_W-3 bits.
module loc_decode #(
    parameter int SECT_BYTES = 512,
    parameter int CODE_BYTES = 13,
    parameter int LOC_W      = 13,
    parameter int ADDR_W     = 9
) (
    input  logic [LOC_W-1:0]  loc,
    output logic              hit,
    output logic              to_ecc,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        mask
);
    localparam int LIMIT = SECT_BYTES + CODE_BYTES;
    localparam int BB_W  = LOC_W - 3;

    logic [BB_W-1:0] byte_back;
    logic [BB_W-1:0] pos;

    // Position arithmetic and target selection.
    always_comb begin
        byte_back = loc[LOC_W-1:3];
        pos       = BB_W'(LIMIT - 1) - byte_back;
        hit       = (byte_back < BB_W'(LIMIT));
        to_ecc    = (pos >= BB_W'(SECT_BYTES));
        addr      = to_ecc ? ADDR_W'(pos - BB_W'(SECT_BYTES)) : ADDR_W'(pos);
        mask      = 8'd1 << loc[2:0];
    end
endmodule

// File: rtl/bch_errloc_mapper.sv
// Top: screens a sector, then walks up to MAX_ERR locator outputs one per
// clock, issuing flip commands and a final result with a done pulse.
// Assumes start is only honoured in idle; the list is latched at start.
module bch_errloc_mapper
    import bch_map_pkg::*;
#(
    parameter int SECT_BYTES = 512,
    parameter int CODE_BYTES = 13,
    parameter int MAX_ERR    = 8,
    parameter int LOC_W      = 13
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic [(CODE_BYTES+1)*8-1:0]       calc_ecc,
    input  logic [CODE_BYTES*8-1:0]           stored_ecc,
    input  logic                              loc_fail,
    input  logic [$clog2(MAX_ERR+1)-1:0]      loc_count,
    input  logic [MAX_ERR*LOC_W-1:0]          loc_list,
    output logic [(CODE_BYTES+1)*8-1:0]       syn_rev,
    output logic                              wr_valid,
    output logic                              wr_ecc,
    output logic [$clog2(SECT_BYTES)-1:0]     wr_addr,
    output logic [7:0]                        wr_mask,
    output logic                              done,
    output logic [1:0]                        res_code,
    output logic [$clog2(MAX_ERR+1)-1:0]      res_count
);
    localparam int ECC_BYTES = CODE_BYTES + 1;
    localparam int ADDR_W    = $clog2(SECT_BYTES);
    localparam int CNT_W     = $clog2(MAX_ERR + 1);
    localparam int LIST_W    = MAX_ERR * LOC_W;

    st_e               st_q;
    logic [LIST_W-1:0] list_q;
    logic [CNT_W-1:0]  rem_q;
    logic [CNT_W-1:0]  fixes_q;
    logic              bad_q;

    logic              syn_zero;
    logic              erased;
    logic              hit;
    logic              hit_ecc;
    logic [ADDR_W-1:0] hit_addr;
    logic [7:0]        hit_mask;

    ecc_screen #(
        .CODE_BYTES (CODE_BYTES),
        .ECC_BYTES  (ECC_BYTES)
    ) u_screen (
        .calc_ecc   (calc_ecc),
        .stored_ecc (stored_ecc),
        .syn_rev    (syn_rev),
        .syn_zero   (syn_zero),
        .erased     (erased)
    );

    loc_decode #(
        .SECT_BYTES (SECT_BYTES),
        .CODE_BYTES (CODE_BYTES),
        .LOC_W      (LOC_W),
        .ADDR_W     (ADDR_W)
    ) u_decode (
        .loc    (list_q[LOC_W-1:0]),
        .hit    (hit),
        .to_ecc (hit_ecc),
        .addr   (hit_addr),
        .mask   (hit_mask)
    );

    // Job sequencer: screening on start, per-location walk, final report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            list_q    <= '0;
            rem_q     <= '0;
            fixes_q   <= '0;
            bad_q     <= 1'b0;
            wr_valid  <= 1'b0;
            wr_ecc    <= 1'b0;
            wr_addr   <= '0;
            wr_mask   <= '0;
            done      <= 1'b0;
            res_code  <= RES_OK;
            res_count <= '0;
        end else begin
            wr_valid <= 1'b0;
            done     <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        if (syn_zero || erased) begin
                            done      <= 1'b1;
                            res_code  <= RES_OK;
                            res_count <= '0;
                        end else if (loc_fail || loc_count > CNT_W'(MAX_ERR)) begin
                            done      <= 1'b1;
                            res_code  <= RES_FAIL;
                            res_count <= '0;
                        end else if (loc_count == '0) begin
                            done      <= 1'b1;
                            res_code  <= RES_OK;
                            res_count <= '0;
                        end else begin
                            list_q  <= loc_list;
                            rem_q   <= loc_count;
                            fixes_q <= '0;
                            bad_q   <= 1'b0;
                            st_q    <= ST_WALK;
                        end
                    end
                end
                ST_WALK: begin
                    if (hit) begin
                        wr_valid <= 1'b1;
                        wr_ecc   <= hit_ecc;
                        wr_addr  <= hit_addr;
                        wr_mask  <= hit_mask;
                        fixes_q  <= fixes_q + 1'b1;
                    end else begin
                        bad_q <= 1'b1;
                    end
                    list_q <= list_q >> LOC_W;
                    rem_q  <= rem_q - 1'b1;
                    if (rem_q == CNT_W'(1)) begin
                        st_q <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    done      <= 1'b1;
                    res_code  <= bad_q ? RES_BADLOC : RES_OK;
                    res_count <= fixes_q;
                    st_q      <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R6: every command flips exactly one bit.
    assert_one_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $countones(wr_mask) == 1);

    // R8: code-byte commands stay inside the stored code bytes.
    assert_ecc_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ecc) |-> wr_addr < ADDR_W'(CODE_BYTES));

    // R2: a clean syndrome ends the job at once with OK and no flips.
    assert_clean_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && start && syn_zero) |=>
            (done && !wr_valid && res_code == RES_OK && res_count == '0));

    // R3: an erased page ends the job with OK even if the locator failed.
    assert_erased_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && start && !syn_zero && erased) |=>
            (done && !wr_valid && res_code == RES_OK));

    // R4: a locator failure reports FAIL with no flips.
    assert_fail_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && start && !syn_zero && !erased && loc_fail) |=>
            (done && !wr_valid && res_code == RES_FAIL && res_count == '0));

    // R10: the reported count never exceeds the list limit.
    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> res_count <= CNT_W'(MAX_ERR));
endmodule

// File: tb/test_bch_errloc_mapper.sv
// Directed bench for bch_errloc_mapper: one task per scenario.
module test_bch_errloc_mapper;
    localparam int CB = 13;
    localparam int EB = 14;
    localparam int ME = 8;
    localparam int LW = 13;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [EB*8-1:0] calc_ecc = '0;
    logic [CB*8-1:0] stored_ecc = '0;
    logic           loc_fail = 1'b0;
    logic [3:0]     loc_count = '0;
    logic [ME*LW-1:0] loc_list = '0;
    logic [EB*8-1:0] syn_rev;
    logic           wr_valid;
    logic           wr_ecc;
    logic [8:0]     wr_addr;
    logic [7:0]     wr_mask;
    logic           done;
    logic [1:0]     res_code;
    logic [3:0]     res_count;

    bch_errloc_mapper i_bch_errloc_mapper (
        .clk(clk), .rst_n(rst_n), .start(start), .calc_ecc(calc_ecc),
        .stored_ecc(stored_ecc), .loc_fail(loc_fail), .loc_count(loc_count),
        .loc_list(loc_list), .syn_rev(syn_rev), .wr_valid(wr_valid),
        .wr_ecc(wr_ecc), .wr_addr(wr_addr), .wr_mask(wr_mask), .done(done),
        .res_code(res_code), .res_count(res_count)
    );

    always #2 clk = ~clk;

    int n_tot = 0;
    int n_bad = 0;
    int cyc   = 0;

    // Recorded outcome of one job.
    int rec_n;
    int rec_tgt [16];
    int rec_addr[16];
    int rec_mask[16];
    int rec_off [16];
    int done_off;
    int done_cnt;
    int got_code;
    int got_cnt;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_tot++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("test done: total=%0d bad=%0d", n_tot, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_tot++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic normal_bytes();
        for (int i = 0; i < EB; i++) calc_ecc[i*8 +: 8] = 8'(8'h21 + i);
        for (int i = 0; i < CB; i++) stored_ecc[i*8 +: 8] = 8'(8'h40 + i);
    endtask

    task automatic load_list(input int n, input int locs[8]);
        loc_count = 4'(n);
        for (int i = 0; i < ME; i++) loc_list[i*LW +: LW] = LW'(locs[i]);
    endtask

    // Pulse start and record the job over a fixed window.
    task automatic fire();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rec_n = 0; done_off = -1; done_cnt = 0; got_code = -1; got_cnt = -1;
        for (int off = 0; off < 14; off++) begin
            if (off > 0) @(negedge clk);
            if (wr_valid && rec_n < 16) begin
                rec_tgt[rec_n]  = int'(wr_ecc);
                rec_addr[rec_n] = int'(wr_addr);
                rec_mask[rec_n] = int'(wr_mask);
                rec_off[rec_n]  = off;
                rec_n++;
            end
            if (done) begin
                done_cnt++;
                if (done_off < 0) begin
                    done_off = off;
                    got_code = int'(res_code);
                    got_cnt  = int'(res_count);
                end
            end
        end
    endtask

    task automatic expect_exit(input string tag, input int code);
        fire();
        check({tag, " done offset"}, done_off, 0);
        check({tag, " done once"}, done_cnt, 1);
        check({tag, " no writes"}, rec_n, 0);
        check({tag, " code"}, got_code, code);
        check({tag, " count"}, got_cnt, 0);
    endtask

    // Walk a list and compare with the model from R5..R10.
    task automatic t_walk(input string tag, input int n, input int locs[8]);
        int j;
        int bad;
        normal_bytes();
        loc_fail = 1'b0;
        load_list(n, locs);
        fire();
        j = 0; bad = 0;
        for (int i = 0; i < n; i++) begin
            int bb;
            int pos;
            bb = locs[i] / 8;
            if (bb > 524) begin
                bad = 1;
            end else begin
                pos = 524 - bb;
                check({tag, " R5 write cycle"}, rec_off[j], 1 + i);
                check({tag, " R7/R8 target"}, rec_tgt[j], (pos >= 512) ? 1 : 0);
                check({tag, " R7/R8 addr"}, rec_addr[j], (pos >= 512) ? pos - 512 : pos);
                check({tag, " R6 mask"}, rec_mask[j], 1 << (locs[i] % 8));
                j++;
            end
        end
        check({tag, " R9 write count"}, rec_n, j);
        check({tag, " R5 done offset"}, done_off, n + 1);
        check({tag, " R5 done once"}, done_cnt, 1);
        check({tag, " R10 code"}, got_code, bad ? 2 : 0);
        check({tag, " R10 count"}, got_cnt, j);
    endtask

    task automatic t_reset();
        check("R10 reset done", int'(done), 0);
        check("R10 reset wr_valid", int'(wr_valid), 0);
        check("R10 reset code", int'(res_code), 0);
    endtask

    task automatic t_reverse_r1();
        for (int i = 0; i < CB; i++) calc_ecc[i*8 +: 8] = 8'(8'hA0 + i);
        calc_ecc[CB*8 +: 8] = 8'h5C;
        #1;
        for (int g = 0; g < CB; g++)
            check("R1 reversed byte", int'(syn_rev[g*8 +: 8]), 8'hA0 + 12 - g);
        check("R1 pad byte zero", int'(syn_rev[CB*8 +: 8]), 0);
    endtask

    task automatic t_clean_r2(input int locs[8]);
        normal_bytes();
        for (int i = 0; i < CB; i++) calc_ecc[i*8 +: 8] = 8'h00;
        calc_ecc[CB*8 +: 8] = 8'hFF;
        loc_fail = 1'b1;
        load_list(3, locs);
        expect_exit("R2 clean syndrome with fail flag", 0);
    endtask

    task automatic t_erased_r3(input int locs[8]);
        normal_bytes();
        stored_ecc = '1;
        loc_fail = 1'b1;
        load_list(2, locs);
        expect_exit("R3 erased page with fail flag", 0);
        stored_ecc[5*8 +: 8] = 8'hFE;
        expect_exit("R3 almost erased gives R4 fail", 1);
    endtask

    task automatic t_fail_r4(input int locs[8]);
        normal_bytes();
        loc_fail = 1'b1;
        load_list(3, locs);
        expect_exit("R4 locator fail", 1);
        loc_fail = 1'b0;
        loc_count = 4'd9;
        expect_exit("R4 count above limit", 1);
    endtask

    task automatic t_empty_r11();
        normal_bytes();
        loc_fail = 1'b0;
        loc_count = 4'd0;
        expect_exit("R11 empty list", 0);
    endtask

    initial begin
        int la[8];
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reverse_r1();
        la = '{0, 103, 104, 4199, 2000, 0, 0, 0};
        t_clean_r2(la);
        t_erased_r3(la);
        t_fail_r4(la);
        t_empty_r11();
        t_walk("mixed R6 R7 R8", 5, la);
        la = '{7, 96, 111, 600, 1234, 2047, 3000, 4100};
        t_walk("full list R5", 8, la);
        la = '{4200, 50, 8191, 0, 0, 0, 0, 0};
        t_walk("invalid R9", 3, la);
        la = '{4195, 0, 0, 0, 0, 0, 0, 0};
        t_walk("single data byte 0", 1, la);
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end
endmodule